// File: doc/BRIEF.md
# Compact Multicycle I/O Processor

This block is a small, self-running processor whose only job is to move bytes between a register file and peripherals on a narrow byte bus. It fetches 16-bit instructions from a program ROM inside the block. The ROM contents come from a parameter image. Each instruction takes a fixed run of eight clock cycles. A 3-bit state counter steps through those cycles in Gray order, so exactly one state bit changes on every clock. At 50 MHz this gives 6.25 million instructions per second.

Each instruction word splits into three fields. The operation code is in bits 15..12. A register select (one of sixteen 8-bit registers) is in bits 11..8. An 8-bit argument is in bits 7..0. The argument is a peripheral address, an immediate value or a signed branch offset, depending on the operation.

The peripheral side has an 8-bit address, an 8-bit write-data bus and an 8-bit read-data bus. It has separate read and write strobes. A strobe is high for one cycle at most per instruction. The address and write data are already valid one cycle before that cycle and stay unchanged one cycle after it. A test instruction followed by a branch with offset -2 forms a polling loop on a peripheral.

Top module: `iop_core`

The eight states, in order, are:

| State | Code | Work done |
|-------|------|-----------|
| ST_FETCH | 000 | The instruction at the program counter is latched. |
| ST_DECODE | 001 | Address and write data are driven for I/O operations. |
| ST_SETUP | 011 | Setup cycle; nothing changes. |
| ST_STROBE | 010 | The strobe is high; read data is captured at the end of the cycle. |
| ST_HOLD | 110 | Hold cycle; nothing changes. |
| ST_EXEC | 111 | The register and the zero flag are written. |
| ST_IDLE | 101 | Idle cycle. |
| ST_ADVANCE | 100 | The program counter is updated. |

Transitions:
- Each state moves to the next state in the table on every clock.
- ST_ADVANCE returns to ST_FETCH.
- Reset forces ST_FETCH from any state.

## Requirements
- R1: While reset is high, the next clock edge sets the program counter to 0 and the state to ST_FETCH (code 000). The strobes, io_addr and io_wdata are all 0 during reset. The registers and the zero flag clear to 0.
- R2: The state code changes in exactly one bit on every clock outside reset. The codes follow the order 000, 001, 011, 010, 110, 111, 101, 100 and then repeat.
- R3: io_rd and io_wr are never high together. At most one of them is high per instruction, and only in the fourth cycle (ST_STROBE). It is high there for exactly one cycle.
- R4: For an I/O instruction, io_addr equals bits 7..0 of the instruction in ST_SETUP, ST_STROBE and ST_HOLD. For a write, io_wdata equals the selected register in the same three cycles.
- R5: Opcode 0x1 loads bits 7..0 into the register selected by bits 11..8. Opcode 0x3 pulses io_wr with that register's value on io_wdata.
- R6: Opcode 0x2 pulses io_rd. It stores the io_rdata value sampled at the end of ST_STROBE into the selected register.
- R7: Opcode 0x4 replaces the register with register AND immediate. It sets the zero flag when the result is 0 and clears it otherwise.
- R8: Opcode 0x5 sets the zero flag when the register equals the immediate and clears it otherwise. The register is left unchanged.
- R9: Opcode 0x6 (branch when the zero flag is 1) and opcode 0x7 (branch when the zero flag is 0) take a branch by setting the program counter to the current instruction address plus the sign-extended bits 7..0. When not taken, the next address is the current address plus 1. An offset of -2 re-runs the instruction two words back.
- R10: Opcode 0x8 jumps to the address formed by bits 11..0, truncated to the program counter width.
- R11: Opcodes 0x0 and 0x9 to 0xF change no register, no flag and no output. They still take all eight cycles.
- R12: Every instruction takes exactly eight cycles. The program counter changes only at the end of ST_ADVANCE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| io_addr | output | 8 | Peripheral address |
| io_wdata | output | 8 | Peripheral write data |
| io_rdata | input | 8 | Peripheral read data |

## Verification
The bench runs a fixed program with several features:
- A polling loop whose branch offset is -2.
- Taken and not-taken branches of both senses.
- A jump to a high program address.
- An undefined opcode, register 15 and address 0xFF.

Random read data decides how many times the poll loop repeats. The bench checks every cycle against its own instruction model. The failures it targets are:
- A wrong sign extension or a wrong branch base sends execution to the wrong word, so the wrong writes appear or expected writes go missing.
- A strobe one cycle early or late breaks the fixed eight-cycle placement.
- An undefined opcode that writes a register later shows up as wrong data on a write.

A second reset in the middle of the run checks that execution restarts from address 0 with cleared registers.

// File: rtl/iop_pkg.sv
package iop_pkg;

    typedef enum logic [2:0] {
        ST_FETCH   = 3'b000,
        ST_DECODE  = 3'b001,
        ST_SETUP   = 3'b011,
        ST_STROBE  = 3'b010,
        ST_HOLD    = 3'b110,
        ST_EXEC    = 3'b111,
        ST_IDLE    = 3'b101,
        ST_ADVANCE = 3'b100
    } phase_t;

    localparam logic [3:0] OP_NOP  = 4'h0;
    localparam logic [3:0] OP_LDI  = 4'h1;
    localparam logic [3:0] OP_IN   = 4'h2;
    localparam logic [3:0] OP_OUT  = 4'h3;
    localparam logic [3:0] OP_ANDI = 4'h4;
    localparam logic [3:0] OP_CMPI = 4'h5;
    localparam logic [3:0] OP_BZS  = 4'h6;
    localparam logic [3:0] OP_BZC  = 4'h7;
    localparam logic [3:0] OP_JMP  = 4'h8;

    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 4;

    typedef struct packed {
        logic [3:0]        op;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] arg;
    } instr_t;

endpackage

// File: rtl/iop_seq.sv
module iop_seq
    import iop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase
);
    phase_t phase_nx;

    always_comb begin
        unique case (phase)
            ST_FETCH:   phase_nx = ST_DECODE;
            ST_DECODE:  phase_nx = ST_SETUP;
            ST_SETUP:   phase_nx = ST_STROBE;
            ST_STROBE:  phase_nx = ST_HOLD;
            ST_HOLD:    phase_nx = ST_EXEC;
            ST_EXEC:    phase_nx = ST_IDLE;
            ST_IDLE:    phase_nx = ST_ADVANCE;
            ST_ADVANCE: phase_nx = ST_FETCH;
            default:    phase_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= ST_FETCH;
        else     phase <= phase_nx;
    end
endmodule

// File: rtl/iop_rom.sv
module iop_rom #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    parameter logic [WIDTH*DEPTH-1:0] IMAGE = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0]    addr,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign words[g] = IMAGE[g*WIDTH +: WIDTH];
    end

    assign word = words[addr];
endmodule

// File: rtl/iop_regfile.sv
module iop_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[sel] <= wdata;
        end
    end

    assign rdata = regs[sel];
endmodule

// File: rtl/iop_core.sv
module iop_core
    import iop_pkg::*;
#(
    parameter int ROM_DEPTH = 1024,
    parameter logic [INSTR_W*ROM_DEPTH-1:0] IMAGE = '0,
    localparam int PCW  = $clog2(ROM_DEPTH),
    localparam int NREG = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    input  logic [DATA_W-1:0] io_rdata
);
    phase_t             phase;
    logic [PCW-1:0]     pc;
    logic [PCW-1:0]     pc_nx;
    instr_t             ir;
    logic [INSTR_W-1:0] rom_word;
    logic               zflag;
    logic [DATA_W-1:0]  rd_cap;
    logic [DATA_W-1:0]  rf_rdata;
    logic [DATA_W-1:0]  rf_wdata;
    logic               rf_we;
    logic               is_io;

    iop_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    iop_rom #(
        .DEPTH (ROM_DEPTH),
        .WIDTH (INSTR_W),
        .IMAGE (IMAGE)
    ) u_rom (
        .addr (pc),
        .word (rom_word)
    );

    iop_regfile #(
        .NREG (NREG),
        .DW   (DATA_W)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .sel   (ir.sel),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

    assign is_io = (ir.op == OP_IN) || (ir.op == OP_OUT);

    // Register write-back: value and enable, active only in ST_EXEC
    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = rf_rdata;
        unique case (ir.op)
            OP_LDI:  rf_wdata = ir.arg;
            OP_IN:   rf_wdata = rd_cap;
            OP_ANDI: rf_wdata = rf_rdata & ir.arg;
            default: rf_wdata = rf_rdata;
        endcase
        if (phase == ST_EXEC)
            rf_we = (ir.op == OP_LDI) || (ir.op == OP_IN) || (ir.op == OP_ANDI);
    end

    // Next instruction address
    always_comb begin
        logic [PCW-1:0]    off_ext;
        logic [SEL_W+DATA_W-1:0] jump_tgt;
        off_ext  = PCW'($signed(ir.arg));
        jump_tgt = {ir.sel, ir.arg};
        pc_nx    = pc + PCW'(1);
        unique case (ir.op)
            OP_BZS:  if (zflag)  pc_nx = pc + off_ext;
            OP_BZC:  if (!zflag) pc_nx = pc + off_ext;
            OP_JMP:  pc_nx = PCW'(jump_tgt);
            default: pc_nx = pc + PCW'(1);
        endcase
    end

    // Datapath state register, stepped by phase
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            ir       <= '0;
            zflag    <= 1'b0;
            rd_cap   <= '0;
            io_addr  <= '0;
            io_wdata <= '0;
        end else begin
            unique case (phase)
                ST_FETCH: ir <= instr_t'(rom_word);
                ST_DECODE: begin
                    if (is_io)            io_addr  <= ir.arg;
                    if (ir.op == OP_OUT)  io_wdata <= rf_rdata;
                end
                ST_STROBE: if (ir.op == OP_IN) rd_cap <= io_rdata;
                ST_EXEC: begin
                    if (ir.op == OP_ANDI) zflag <= ((rf_rdata & ir.arg) == '0);
                    if (ir.op == OP_CMPI) zflag <= (rf_rdata == ir.arg);
                end
                ST_ADVANCE: pc <= pc_nx;
                default: ;
            endcase
        end
    end

    // Strobe outputs
    always_comb begin
        io_rd = 1'b0;
        io_wr = 1'b0;
        if (phase == ST_STROBE) begin
            io_rd = (ir.op == OP_IN);
            io_wr = (ir.op == OP_OUT);
        end
    end
endmodule

// File: rtl/iop_core_chk.sv
module iop_core_chk
    import iop_pkg::*;
#(
    parameter int PCW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_wdata,
    input phase_t            phase,
    input logic [PCW-1:0]    pc
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == '0) && (phase == ST_FETCH) && !io_rd && !io_wr);

    // R2
    gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($countones(phase ^ $past(phase)) == 1));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && io_wr));

    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd || io_wr) |=> !(io_rd || io_wr));

    // R4
    bus_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd || io_wr) |-> ($stable(io_addr) && $stable(io_wdata)));

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd || io_wr) |=> ($stable(io_addr) && $stable(io_wdata)));

    // R12
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_ADVANCE) |=> $stable(pc));
endmodule

bind iop_core iop_core_chk #(.PCW(PCW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .phase    (phase),
    .pc       (pc)
);

// File: tb/iop_core_tb_top.sv
module iop_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int POLL_ADDR  = 8'h30;

    function automatic logic [16*DEPTH-1:0] build_image();
        logic [16*DEPTH-1:0] img;
        logic [15:0] w;
        img = '0;
        for (int i = 0; i < DEPTH; i++) begin
            case (i)
                0:   w = 16'h105A; // load r0 = 0x5A
                1:   w = 16'h3010; // out r0 -> 0x10
                2:   w = 16'h1FFF; // load r15 = 0xFF
                3:   w = 16'h3FFF; // out r15 -> 0xFF
                4:   w = 16'h2220; // in r2 <- 0x20
                5:   w = 16'h3221; // out r2 -> 0x21
                6:   w = 16'h2330; // in r3 <- poll address
                7:   w = 16'h4303; // and r3, 0x03
                8:   w = 16'h60FE; // branch if zero, -2
                9:   w = 16'h3331; // out r3 -> 0x31
                10:  w = 16'h505A; // compare r0, 0x5A (equal)
                11:  w = 16'h6002; // taken
                12:  w = 16'h30EE; // skipped
                13:  w = 16'h505B; // compare r0, 0x5B (differs)
                14:  w = 16'h7002; // taken
                15:  w = 16'h30EF; // skipped
                16:  w = 16'hF123; // undefined
                17:  w = 16'h6002; // not taken
                18:  w = 16'h3F40; // out r15 -> 0x40
                19:  w = 16'h4000; // and r0, 0 -> zero
                20:  w = 16'h7005; // not taken
                21:  w = 16'h3041; // out r0 -> 0x41
                22:  w = 16'h8300; // jump 0x300
                768: w = 16'h8004; // jump 4
                default: w = 16'h0000;
            endcase
            img[i*16 +: 16] = w;
        end
        return img;
    endfunction

    localparam logic [16*DEPTH-1:0] PROG = build_image();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_rd, io_wr;
    logic [7:0] io_addr, io_wdata;
    logic [7:0] io_rdata = 8'h00;

    int checks = 0;
    int errors = 0;

    int         m_pc;
    logic [7:0] m_reg [16];
    logic       m_z;

    always #(CLK_PERIOD/2) clk = ~clk;

    iop_core #(.ROM_DEPTH(DEPTH), .IMAGE(PROG)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata)
    );

    function automatic string tag_of(int pc, logic [3:0] op);
        case (pc)
            1, 3:    return "R5";
            4, 768:  return "R10";
            5:       return "R6";
            6:       return "R9";
            9, 21:   return "R7";
            18:      return "R8";
            default: return (op > 4'h8 || op == 4'h0) ? "R11" : "R3";
        endcase
    endfunction

    function automatic logic [7:0] pick_rdata(logic [7:0] addr);
        int r;
        r = $urandom_range(0, 7);
        if (r == 0) return 8'h00;
        if (r == 1) return 8'hFF;
        if (addr == POLL_ADDR[7:0] && r < 5) return 8'h00 | (8'($urandom) & 8'hFC);
        return 8'($urandom);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s pc=%0d actual=%0h expected=%0h", tag, what, m_pc, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0;
        m_z  = 1'b0;
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        io_rdata = 8'h00;
        repeat (3) @(negedge clk);
        check("R1", {30'd0, io_rd, io_wr}, 32'd0, "strobes in reset");
        check("R1", {16'd0, io_addr, io_wdata}, 32'd0, "bus in reset");
        rst = 1'b0;
        model_reset();
    endtask

    task automatic run_instr();
        logic [15:0] w;
        logic [3:0]  op, sel;
        logic [7:0]  arg, rv, res;
        logic        ex_rd, ex_wr;
        string       t;
        w   = PROG[m_pc*16 +: 16];
        op  = w[15:12];
        sel = w[11:8];
        arg = w[7:0];
        rv  = pick_rdata(arg);
        io_rdata = rv;
        t = tag_of(m_pc, op);
        for (int off = 0; off < 8; off++) begin
            ex_rd = (off == 3) && (op == 4'h2);
            ex_wr = (off == 3) && (op == 4'h3);
            check(off == 0 ? "R12" : (off == 1 ? "R2" : t),
                  {30'd0, io_rd, io_wr}, {30'd0, ex_rd, ex_wr}, "strobes");
            if (off >= 2 && off <= 4 && (op == 4'h2 || op == 4'h3))
                check("R4", {24'd0, io_addr}, {24'd0, arg}, "address");
            if (off >= 2 && off <= 4 && op == 4'h3)
                check(t, {24'd0, io_wdata}, {24'd0, m_reg[sel]}, "write data");
            @(negedge clk);
        end
        case (op)
            4'h1: begin m_reg[sel] = arg; m_pc = m_pc + 1; end
            4'h2: begin m_reg[sel] = rv;  m_pc = m_pc + 1; end
            4'h4: begin
                res = m_reg[sel] & arg;
                m_reg[sel] = res;
                m_z = (res == 8'h00);
                m_pc = m_pc + 1;
            end
            4'h5: begin m_z = (m_reg[sel] == arg); m_pc = m_pc + 1; end
            4'h6: m_pc = m_z  ? m_pc + int'($signed(arg)) : m_pc + 1;
            4'h7: m_pc = !m_z ? m_pc + int'($signed(arg)) : m_pc + 1;
            4'h8: m_pc = int'({sel, arg});
            default: m_pc = m_pc + 1;
        endcase
        m_pc = m_pc & (DEPTH - 1);
    endtask

    initial begin
        void'($urandom(32'h0005EED1));
        model_reset();
        do_reset();
        repeat (300) run_instr();
        // mid-run reset: restart from address 0 with cleared state
        @(negedge clk);
        do_reset();
        repeat (140) run_instr();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired pc=%0d actual=running expected=done", m_pc);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule